// File: doc/BRIEF.md
# Looping Descriptor Audio DMA Channel

This block is one DMA channel that streams audio samples between a memory buffer and a single fixed data register of a serial audio peripheral. Software builds a ring of descriptors in memory. Each descriptor is four 32-bit words: the source address at +0, the destination address at +4, the byte count at +8 and the address of the next descriptor at +12. Software writes the address of the first descriptor, then writes the mode register with the go bit set. From then on the channel walks the ring with no further help from software. It fetches a descriptor, moves that descriptor's bytes one access at a time, raises an end-of-segment flag and follows the next pointer. The last descriptor points back to the first, so the stream repeats until software aborts it.

The peripheral side keeps a fixed address while the memory side advances. A narrow access to the 32-bit peripheral register goes to the byte lane that a big-endian register expects. When external pacing is on, the channel stays armed and waits for a request from the peripheral. Each request allows a programmed byte quota to move, and then the channel samples the request again.

Register map, word index on `reg_addr`:
- 0: mode
- 1: status
- 2: first descriptor address
- 3: remaining byte count
- 4: current source address
- 5: current destination address

Mode register bits:
- [0] go
- [1] abort
- [2] external pacing
- [3] hold source
- [4] hold destination
- [6:5] source size code
- [8:7] destination size code
- [9] end-of-segment interrupt enable
- [10] error interrupt enable
- [18:11] burst quota in bytes

The size codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. Status register bits:
- [0] segment done
- [1] programming error
- [2] transfer error
- [3] busy, read-only

Top module: `audio_chain_dma`

## Requirements
- R1: After reset the mode and status registers read zero, `irq` is low and `mem_req` is low.
- R2: A mode write with go=1 and abort=0 while idle fetches the four descriptor words from the first-descriptor address. The channel then moves the descriptor's byte count with accesses whose `mem_size` equals the size code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). The remaining count drops by the access size after each write and stops at zero.
- R3: A held side keeps its base address, and each access to it adds a lane offset of +3 for 1-byte, +2 for 2-byte and +0 for 4-byte accesses. A side that is not held advances by the access size after each write.
- R4: When a segment ends, the channel loads the descriptor at that descriptor's next pointer. A ring that points back to its start repeats forever.
- R5: Status bit 0 is set when a segment's last write completes. `irq` is high while that bit is set and mode bit 9 is 1.
- R6: With mode bit 2 set, the channel moves no data until it samples `per_req` high. After that it moves accesses until the bytes moved reach the burst quota in mode bits [18:11], and then waits for `per_req` again.
- R7: A mode write that turns external pacing on while the count register is nonzero sets status bit 1 and does not start the channel. So does a go write whose size codes differ or equal 3.
- R8: `mem_err` on an acknowledged access sets status bit 2 and returns the channel to idle. `irq` is high while bit 1 or bit 2 is set and mode bit 10 is 1.
- R9: Writing ones to status bits [2:0] clears those bits. Writing zeros leaves them unchanged.
- R10: A mode write with bit 1 set stops the channel at once, with no further memory access, and clears the mode register.
- R11: Registers 3, 4 and 5 read back the live remaining count, source address and destination address at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data, right-justified |
| mem_ack | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Completing access failed |
| per_req | input | 1 | Peripheral transfer request |
| irq | output | 1 | Interrupt |

## Verification
The bench runs a two-descriptor playback ring for two full laps. A channel that stopped after the last descriptor, or that refetched from the wrong pointer, would starve the scoreboard or deliver data from the wrong period. It then checks the held peripheral address with its lane offset, for a 2-byte write and for a 1-byte read. A design that advanced the held side, or that used the base address, would put every sample at a wrong address. Under external pacing the bench holds the request low and counts beats per request. A channel that ignored the request, or that missed the quota by one access, shows up as extra or missing writes. The bench also checks that a programming error blocks the start and that a bus error halts the channel.

// File: rtl/audio_chain_dma.sv
module audio_chain_dma #(
  parameter int QW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [1:0]  mem_size,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic        per_req,
  output logic        irq
);
  localparam int MTOP = 10 + QW;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WAIT, S_RD, S_WR} st_t;

  st_t          st;
  logic [MTOP:2] mode_q;
  logic         eos_q, pe_q, te_q;
  logic [31:0]  fda_q, bcr_q, src_q, dst_q, nxt_q, desc_q, data_q;
  logic [1:0]   idx_q;
  logic [QW:0]  burst_q;

  function automatic logic [31:0] lane_off(input logic [1:0] c);
    return (c == 2'd0) ? 32'd3 : (c == 2'd1) ? 32'd2 : 32'd0;
  endfunction

  wire        ext    = mode_q[2];
  wire        shold  = mode_q[3];
  wire        dhold  = mode_q[4];
  wire [1:0]  ssz    = mode_q[6:5];
  wire [1:0]  dsz    = mode_q[8:7];
  wire [QW:0] quota  = {1'b0, mode_q[MTOP:11]};
  wire [QW:0] beat9  = (QW+1)'(1) << ssz;
  wire [31:0] beat   = 32'd1 << ssz;
  wire        last   = bcr_q <= beat;

  wire        wr_mode = reg_we && reg_addr == 3'd0;
  wire        wr_stat = reg_we && reg_addr == 3'd1;
  wire        sz_bad  = reg_wdata[6:5] == 2'd3 || reg_wdata[6:5] != reg_wdata[8:7];
  wire        pe_set  = wr_mode && ((reg_wdata[2] && !ext && bcr_q != 32'd0) ||
                                    (reg_wdata[0] && sz_bad));
  wire        abort   = wr_mode && reg_wdata[1];
  wire        start   = wr_mode && reg_wdata[0] && !reg_wdata[1] && !pe_set && st == S_IDLE;

  assign mem_req   = st == S_FETCH || st == S_RD || st == S_WR;
  assign mem_we    = st == S_WR;
  assign mem_wdata = data_q;
  assign mem_size  = (st == S_FETCH) ? 2'd2 : (st == S_RD) ? ssz : dsz;
  assign mem_addr  = (st == S_FETCH) ? desc_q + {28'd0, idx_q, 2'b00} :
                     (st == S_RD)    ? (shold ? src_q + lane_off(ssz) : src_q) :
                                       (dhold ? dst_q + lane_off(dsz) : dst_q);

  assign irq = (eos_q && mode_q[9]) || ((pe_q || te_q) && mode_q[10]);

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = 32'(mode_q) << 2;
      3'd1:    reg_rdata = {28'd0, st != S_IDLE, te_q, pe_q, eos_q};
      3'd2:    reg_rdata = fda_q;
      3'd3:    reg_rdata = bcr_q;
      3'd4:    reg_rdata = src_q;
      3'd5:    reg_rdata = dst_q;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      mode_q <= '0;
      {eos_q, pe_q, te_q} <= 3'b000;
      fda_q <= '0; bcr_q <= '0; src_q <= '0; dst_q <= '0;
      nxt_q <= '0; desc_q <= '0; data_q <= '0;
      idx_q <= '0; burst_q <= '0;
    end else begin
      if (wr_stat) begin
        if (reg_wdata[0]) eos_q <= 1'b0;
        if (reg_wdata[1]) pe_q  <= 1'b0;
        if (reg_wdata[2]) te_q  <= 1'b0;
      end
      if (pe_set) pe_q <= 1'b1;
      if (abort)       mode_q <= '0;
      else if (wr_mode) begin
        mode_q <= reg_wdata[MTOP:2];
        if (pe_set) mode_q[2] <= 1'b0;
      end
      if (reg_we && reg_addr == 3'd2) fda_q <= reg_wdata;
      if (reg_we && reg_addr == 3'd3 && st == S_IDLE) bcr_q <= reg_wdata;

      if (abort) st <= S_IDLE;
      else begin
        case (st)
          S_IDLE: if (start) begin
            desc_q <= fda_q; idx_q <= 2'd0; st <= S_FETCH;
          end
          S_FETCH: if (mem_ack) begin
            if (mem_err) begin te_q <= 1'b1; st <= S_IDLE; end
            else begin
              case (idx_q)
                2'd0: src_q <= mem_rdata;
                2'd1: dst_q <= mem_rdata;
                2'd2: bcr_q <= mem_rdata;
                default: nxt_q <= mem_rdata;
              endcase
              idx_q <= idx_q + 2'd1;
              if (idx_q == 2'd3) st <= S_WAIT;
            end
          end
          S_WAIT: if (!ext || per_req) begin
            burst_q <= '0; st <= S_RD;
          end
          S_RD: if (mem_ack) begin
            if (mem_err) begin te_q <= 1'b1; st <= S_IDLE; end
            else begin data_q <= mem_rdata; st <= S_WR; end
          end
          S_WR: if (mem_ack) begin
            if (mem_err) begin te_q <= 1'b1; st <= S_IDLE; end
            else begin
              if (!shold) src_q <= src_q + beat;
              if (!dhold) dst_q <= dst_q + beat;
              bcr_q <= last ? 32'd0 : bcr_q - beat;
              if (last) begin
                eos_q <= 1'b1; desc_q <= nxt_q; idx_q <= 2'd0; st <= S_FETCH;
              end else if (burst_q + beat9 >= quota) st <= S_WAIT;
              else begin burst_q <= burst_q + beat9; st <= S_RD; end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !mem_req);
  // R2
  size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_size != 2'd3);
  // R2
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && mem_ack && !mem_err) |=> bcr_q <= $past(bcr_q));
  // R3
  dst_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && mem_ack && !mem_err && dhold) |=> $stable(dst_q));
  // R5
  eos_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eos_q) |-> $past(st == S_WR && mem_ack));
  // R6
  pace_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && ext && !per_req) |=> !mem_req);
  // R10
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0 && reg_wdata[1]) |=> !mem_req);
endmodule

// File: tb/audio_chain_dma_bench.sv
`timescale 1ns/100ps
module audio_chain_dma_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0] mem_size;
  logic per_req = 1'b0, irq;
  logic force_err = 1'b0;

  always #2.5 clk = ~clk;

  audio_chain_dma u_audio_chain_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .per_req(per_req), .irq(irq));

  localparam logic [31:0] PER = 32'h800;
  logic [7:0] mem [0:2047];
  logic [7:0] per_cnt = 8'h40;
  int checks = 0, fails = 0, wr_seen = 0;
  string cur_tag = "R2";

  typedef struct packed { logic [31:0] a; logic [1:0] s; logic [31:0] d; } item_t;
  item_t exp_q[$];

  assign mem_ack = mem_req;
  assign mem_err = mem_req & force_err;

  always_comb begin
    logic [10:0] a;
    a = mem_addr[10:0];
    if (mem_addr == PER + 32'd3) mem_rdata = {24'd0, per_cnt};
    else case (mem_size)
      2'd0: mem_rdata = {24'd0, mem[a]};
      2'd1: mem_rdata = {16'd0, mem[a + 11'd1], mem[a]};
      default: mem_rdata = {mem[a + 11'd3], mem[a + 11'd2], mem[a + 11'd1], mem[a]};
    endcase
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_req && !mem_we && mem_addr == PER + 32'd3) per_cnt = per_cnt + 8'd1;
    if (mem_req && mem_we) begin
      wr_seen++;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected write actual=%h@%h expected=none", cur_tag, mem_wdata, mem_addr);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        if (e.a !== mem_addr || e.s !== mem_size || e.d !== mem_wdata) begin
          fails++;
          $display("FAIL %s actual=%h/%0d/%h expected=%h/%0d/%h", cur_tag,
                   mem_addr, mem_size, mem_wdata, e.a, e.s, e.d);
        end
      end
    end
  end

  task automatic put32(input int a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[a + i] = v[8*i +: 8];
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic push_half(input int a);
    exp_q.push_back('{PER + 32'd2, 2'd1, {16'd0, mem[a + 1], mem[a]}});
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
    chk({cur_tag, " drained"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  localparam logic [31:0] M_GO = 32'h1, M_AB = 32'h2, M_EXT = 32'h4, M_SH = 32'h8,
                          M_DH = 32'h10, M_S2 = 32'h20 | 32'h80, M_EOSIE = 32'h200,
                          M_ERRIE = 32'h400, M_Q4 = 32'd4 << 11;

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
    for (int i = 0; i < 16; i++) mem[32'h100 + i] = 8'(i * 7 + 3);
    put32(32'h40, 32'h100); put32(32'h44, PER); put32(32'h48, 8); put32(32'h4C, 32'h50);
    put32(32'h50, 32'h108); put32(32'h54, PER); put32(32'h58, 8); put32(32'h5C, 32'h40);
    put32(32'h60, PER); put32(32'h64, 32'h200); put32(32'h68, 4); put32(32'h6C, 32'h60);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rreg(3'd0, v); chk("R1 mode", v, 0);
    rreg(3'd1, v); chk("R1 status", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 req", mem_req, 0);

    // R3 R4 playback ring, held destination at +2, two laps
    cur_tag = "R4";
    for (int lap = 0; lap < 2; lap++)
      for (int i = 0; i < 16; i += 2) push_half(32'h100 + i);
    wreg(3'd2, 32'h40);
    wreg(3'd0, M_GO | M_DH | M_S2 | M_EOSIE | M_Q4);
    drain();
    wreg(3'd0, M_AB);
    // R5 segment flag and irq
    chk("R5 irq after abort clears enable", irq, 0);
    rreg(3'd1, v); chk("R5 eos flag", v[0], 1);
    // R10 abort
    repeat (5) @(negedge clk);
    chk("R10 no req", mem_req, 0);
    rreg(3'd1, v); chk("R10 idle", v[3], 0);
    // R9 clear
    wreg(3'd1, 32'h1);
    rreg(3'd1, v); chk("R9 eos cleared", v, 0);

    // R3 capture: held 1-byte source at +3, memory side increments
    cur_tag = "R3";
    for (int k = 0; k < 8; k++)
      exp_q.push_back('{32'h200 + 32'(k % 4), 2'd0, 32'(8'h41 + k)});
    wreg(3'd2, 32'h60);
    wreg(3'd0, M_GO | M_SH | M_Q4);
    drain();
    wreg(3'd0, M_AB);
    wreg(3'd1, 32'h7);

    // R6 external pacing with 4-byte quota, 2-byte beats
    cur_tag = "R6";
    wreg(3'd3, 32'd0);
    wreg(3'd2, 32'h40);
    v = wr_seen;
    wreg(3'd0, M_GO | M_EXT | M_DH | M_S2 | M_Q4);
    repeat (30) @(negedge clk);
    chk("R6 no data without request", wr_seen, v);
    rreg(3'd1, v); chk("R6 armed busy", v[3], 1);
    push_half(32'h100); push_half(32'h102);
    v = wr_seen;
    @(negedge clk) per_req = 1'b1;
    @(negedge clk) per_req = 1'b0;
    repeat (20) @(negedge clk);
    chk("R6 quota beats", wr_seen - v, 2);
    // R11 readback
    rreg(3'd4, v); chk("R11 src", v, 32'h104);
    rreg(3'd5, v); chk("R11 dst", v, PER);
    rreg(3'd3, v); chk("R11 count", v, 4);
    push_half(32'h104); push_half(32'h106);
    @(negedge clk) per_req = 1'b1;
    @(negedge clk) per_req = 1'b0;
    repeat (20) @(negedge clk);
    chk("R6 second burst drained", exp_q.size(), 0);
    rreg(3'd1, v); chk("R5 eos after segment", v[0], 1);
    wreg(3'd0, M_AB);
    wreg(3'd1, 32'h7);

    // R7 programming errors
    cur_tag = "R7";
    wreg(3'd3, 32'd5);
    wreg(3'd0, M_GO | M_EXT | M_ERRIE | M_S2);
    rreg(3'd1, v); chk("R7 pe not started", v, 32'h2);
    chk("R8 err irq", irq, 1);
    wreg(3'd1, 32'h2);
    rreg(3'd1, v); chk("R9 pe cleared", v, 0);
    chk("R9 irq low", irq, 0);
    wreg(3'd0, M_GO | 32'h20);
    rreg(3'd1, v); chk("R7 size mismatch", v, 32'h2);
    wreg(3'd1, 32'h2);

    // R8 transfer error
    cur_tag = "R8";
    force_err = 1'b1;
    wreg(3'd2, 32'h40);
    wreg(3'd0, M_GO | M_ERRIE | M_S2);
    repeat (4) @(negedge clk);
    rreg(3'd1, v); chk("R8 te stopped", v, 32'h4);
    chk("R8 irq", irq, 1);
    chk("R8 no req", mem_req, 0);
    force_err = 1'b0;
    wreg(3'd1, 32'h4);
    rreg(3'd1, v); chk("R9 te cleared", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule